// File: doc/BRIEF.md
# Source Address Intrusion Detector

This block guards the ports of a multi-port repeater against unknown senders. It holds two reference source addresses for each port. The first is a learned address that tracks the most recent sender on that port. The second is a preferred address that the processor configures. When a packet finishes on a port without errors, the block compares the packet's 48-bit source address with whichever references are enabled for that port. If the packet fails the check, the block raises a latched disable for that port. The port enable logic outside the block acts on that disable.

A separate mask controls each reference, and the two masks can be combined. With only one reference enabled, any mismatch trips the port. With both enabled, a packet trips the port only when its address matches neither reference. The learned register is written automatically whenever a clean packet carries a different address, unless that port's lock bit is set. Locking does not stop the processor from writing the register directly.

The processor reaches every register through one flat address space. Bits [5:4] of the address select a bank and bits [3:0] select an entry within it. The default build has fourteen ports: twelve twisted-pair ports, followed by the attachment-unit port at index 12 and the remote attachment-unit port at index 13.

Top module: `sa_intrusion`

## Requirements
- R1: The register map is as follows. Address 0x00 is the learned-reference enable mask, 0x01 the preferred-reference enable mask, 0x02 the learn-lock mask and 0x03 the port disable status, with bit p of each belonging to port p. Addresses 0x10+p hold the learned address of port p and 0x20+p hold its preferred address. A write with reg_we high takes effect at the next clock edge. reg_rdata shows the addressed register combinationally. Addresses that are not mapped read as zero and ignore writes.
- R2: Only a completion strobe with pkt_err low is considered. An errored packet neither disables a port nor changes its learned address.
- R3: A port with both enable bits clear is never disabled by a packet.
- R4: With only the learned-reference enable set, a clean packet disables its port when its source address differs from the learned address held before that packet's edge.
- R5: With only the preferred-reference enable set, a clean packet disables its port when its source address differs from the preferred address.
- R6: With both enables set, a clean packet disables its port only when its source address matches neither reference.
- R7: On an unlocked port, a clean packet whose source address differs from the learned address replaces it. The new value is readable after the same edge that evaluates the packet.
- R8: A set lock bit stops learning on that port. Processor writes to that port's learned address still take effect.
- R9: A disable bit rises at the edge that evaluates the offending packet. It is cleared only by writing 1 to that bit of address 0x03. A new intrusion in the same cycle as the clear wins, and a processor write to a learned address wins over learning in the same cycle.
- R10: Reset, which is synchronous and active high, clears every mask, every disable bit and every stored address.
- R11: A completion strobe whose port index is 14 or above has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_done | input | 1 | One-cycle strobe: a received packet has ended |
| pkt_port | input | 4 | Port index of the ended packet |
| pkt_sa | input | 48 | Source address of the ended packet |
| pkt_err | input | 1 | High if the ended packet had any error |
| reg_we | input | 1 | Processor write enable |
| reg_addr | input | 6 | Processor register address |
| reg_wdata | input | 48 | Processor write data |
| reg_rdata | output | 48 | Read data of the addressed register |
| port_disable | output | 14 | Latched per-port disable, one bit per port |

## Verification
Two pairs of functions can act in the same cycle. A processor write-1-to-clear of a port's disable bit can coincide with a fresh intrusion on that same port. A processor write to a port's learned address can coincide with a clean packet on that port that would otherwise learn a new address. The bench provokes each pair by driving the register write and the completion strobe together in one cycle. It judges the outcome against its behavioural model: the disable bit must stay set and the learned register must hold the processor's value. The model is compared with port_disable and with the read-back of the addressed register on every clock.

// File: rtl/sai_pkg.sv
package sai_pkg;

    localparam int SA_WIDTH = 48;

    // Top two address bits select a register bank
    typedef enum logic [1:0] {
        BANK_CTRL = 2'd0,
        BANK_LAST = 2'd1,
        BANK_PREF = 2'd2,
        BANK_RSVD = 2'd3
    } bank_e;

    // Entries inside the control bank
    typedef enum logic [1:0] {
        CR_EN_LAST = 2'd0,
        CR_EN_PREF = 2'd1,
        CR_LOCK    = 2'd2,
        CR_DISABLE = 2'd3
    } ctrl_e;

    typedef struct packed {
        logic en_last;
        logic en_pref;
        logic hit_last;
        logic hit_pref;
    } match_t;

    typedef struct packed {
        logic intrude;
        logic learn;
    } verdict_t;

    // A port fails when some reference is enabled and no enabled one matched
    function automatic logic intrusion(input match_t m);
        return (m.en_last || m.en_pref) &&
               !((m.en_last && m.hit_last) || (m.en_pref && m.hit_pref));
    endfunction

endpackage

// File: rtl/sai_addr_bank.sv
module sai_addr_bank #(
    parameter int NUM_PORTS = 14,
    parameter int SA_W      = 48,
    parameter int IDX_W     = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [SA_W-1:0]                 wr_data,
    input  logic                            learn_en,
    input  logic [IDX_W-1:0]                learn_idx,
    input  logic [SA_W-1:0]                 learn_data,
    output logic [NUM_PORTS-1:0][SA_W-1:0]  q
);

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_entry
        logic hit_wr;
        logic hit_learn;
        assign hit_wr    = wr_en    && (wr_idx    == IDX_W'(i));
        assign hit_learn = learn_en && (learn_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= '0;
            end else if (hit_wr) begin
                // processor access takes priority over learning
                q[i] <= wr_data;
            end else if (hit_learn) begin
                q[i] <= learn_data;
            end
        end
    end

endmodule

// File: rtl/sai_ctrl_regs.sv
module sai_ctrl_regs #(
    parameter int NUM_PORTS = 14
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en_last,
    input  logic                  wr_en_pref,
    input  logic                  wr_lock,
    input  logic                  wr_clear,
    input  logic [NUM_PORTS-1:0]  wdata,
    input  logic [NUM_PORTS-1:0]  set_dis,
    output logic [NUM_PORTS-1:0]  en_last,
    output logic [NUM_PORTS-1:0]  en_pref,
    output logic [NUM_PORTS-1:0]  lock,
    output logic [NUM_PORTS-1:0]  dis
);

    logic [NUM_PORTS-1:0] clear_mask;
    assign clear_mask = wr_clear ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_last <= '0;
            en_pref <= '0;
            lock    <= '0;
            dis     <= '0;
        end else begin
            if (wr_en_last) en_last <= wdata;
            if (wr_en_pref) en_pref <= wdata;
            if (wr_lock)    lock    <= wdata;
            // a fresh intrusion overrides a clear in the same cycle
            dis <= (dis & ~clear_mask) | set_dis;
        end
    end

endmodule

// File: rtl/sai_decide.sv
module sai_decide
    import sai_pkg::*;
#(
    parameter int NUM_PORTS = 14,
    parameter int SA_W      = 48,
    parameter int IDX_W     = 4
) (
    input  logic                            pkt_done,
    input  logic [IDX_W-1:0]                pkt_port,
    input  logic [SA_W-1:0]                 pkt_sa,
    input  logic                            pkt_err,
    input  logic [NUM_PORTS-1:0][SA_W-1:0]  last_q,
    input  logic [NUM_PORTS-1:0][SA_W-1:0]  pref_q,
    input  logic [NUM_PORTS-1:0]            en_last,
    input  logic [NUM_PORTS-1:0]            en_pref,
    input  logic [NUM_PORTS-1:0]            lock,
    output logic [NUM_PORTS-1:0]            port_sel,
    output verdict_t                        verdict
);

    localparam logic [IDX_W:0] PORT_LIMIT = (IDX_W+1)'(NUM_PORTS);

    logic            clean;
    logic [SA_W-1:0] ref_last;
    logic [SA_W-1:0] ref_pref;
    logic            lock_bit;
    match_t          m;

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_sel
        assign port_sel[i] = (pkt_port == IDX_W'(i));
    end

    assign clean = pkt_done && !pkt_err && ({1'b0, pkt_port} < PORT_LIMIT);

    always_comb begin
        ref_last  = '0;
        ref_pref  = '0;
        lock_bit  = 1'b0;
        m         = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (port_sel[i]) begin
                ref_last  = last_q[i];
                ref_pref  = pref_q[i];
                lock_bit  = lock[i];
                m.en_last = en_last[i];
                m.en_pref = en_pref[i];
            end
        end
        m.hit_last      = (pkt_sa == ref_last);
        m.hit_pref      = (pkt_sa == ref_pref);
        verdict.intrude = clean && intrusion(m);
        verdict.learn   = clean && !lock_bit && !m.hit_last;
    end

endmodule

// File: rtl/sa_intrusion.sv
module sa_intrusion
    import sai_pkg::*;
#(
    parameter int NUM_PORTS = 14,
    parameter int SA_W      = SA_WIDTH,
    localparam int IDX_W    = $clog2(NUM_PORTS),
    localparam int RA_W     = IDX_W + 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pkt_done,
    input  logic [IDX_W-1:0]      pkt_port,
    input  logic [SA_W-1:0]       pkt_sa,
    input  logic                  pkt_err,
    input  logic                  reg_we,
    input  logic [RA_W-1:0]       reg_addr,
    input  logic [SA_W-1:0]       reg_wdata,
    output logic [SA_W-1:0]       reg_rdata,
    output logic [NUM_PORTS-1:0]  port_disable
);

    bank_e                          reg_bank;
    logic [IDX_W-1:0]               reg_idx;
    logic                           ctrl_slot;
    ctrl_e                          ctrl_sel;
    logic [NUM_PORTS-1:0][SA_W-1:0] last_q;
    logic [NUM_PORTS-1:0][SA_W-1:0] pref_q;
    logic [NUM_PORTS-1:0]           en_last;
    logic [NUM_PORTS-1:0]           en_pref;
    logic [NUM_PORTS-1:0]           lock_mask;
    logic [NUM_PORTS-1:0]           port_sel;
    logic [NUM_PORTS-1:0]           set_dis;
    verdict_t                       verdict;

    assign reg_bank  = bank_e'(reg_addr[RA_W-1:IDX_W]);
    assign reg_idx   = reg_addr[IDX_W-1:0];
    assign ctrl_slot = (reg_bank == BANK_CTRL) && ((reg_idx >> 2) == '0);
    assign ctrl_sel  = ctrl_e'(reg_idx[1:0]);

    sai_decide #(
        .NUM_PORTS(NUM_PORTS), .SA_W(SA_W), .IDX_W(IDX_W)
    ) u_decide (
        .pkt_done (pkt_done),
        .pkt_port (pkt_port),
        .pkt_sa   (pkt_sa),
        .pkt_err  (pkt_err),
        .last_q   (last_q),
        .pref_q   (pref_q),
        .en_last  (en_last),
        .en_pref  (en_pref),
        .lock     (lock_mask),
        .port_sel (port_sel),
        .verdict  (verdict)
    );

    assign set_dis = verdict.intrude ? port_sel : '0;

    sai_ctrl_regs #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en_last (reg_we && ctrl_slot && ctrl_sel == CR_EN_LAST),
        .wr_en_pref (reg_we && ctrl_slot && ctrl_sel == CR_EN_PREF),
        .wr_lock    (reg_we && ctrl_slot && ctrl_sel == CR_LOCK),
        .wr_clear   (reg_we && ctrl_slot && ctrl_sel == CR_DISABLE),
        .wdata      (reg_wdata[NUM_PORTS-1:0]),
        .set_dis    (set_dis),
        .en_last    (en_last),
        .en_pref    (en_pref),
        .lock       (lock_mask),
        .dis        (port_disable)
    );

    sai_addr_bank #(
        .NUM_PORTS(NUM_PORTS), .SA_W(SA_W), .IDX_W(IDX_W)
    ) u_last (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_we && reg_bank == BANK_LAST),
        .wr_idx     (reg_idx),
        .wr_data    (reg_wdata),
        .learn_en   (verdict.learn),
        .learn_idx  (pkt_port),
        .learn_data (pkt_sa),
        .q          (last_q)
    );

    sai_addr_bank #(
        .NUM_PORTS(NUM_PORTS), .SA_W(SA_W), .IDX_W(IDX_W)
    ) u_pref (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_we && reg_bank == BANK_PREF),
        .wr_idx     (reg_idx),
        .wr_data    (reg_wdata),
        .learn_en   (1'b0),
        .learn_idx  ('0),
        .learn_data ('0),
        .q          (pref_q)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_bank)
            BANK_CTRL: begin
                if (ctrl_slot) begin
                    unique case (ctrl_sel)
                        CR_EN_LAST: reg_rdata[NUM_PORTS-1:0] = en_last;
                        CR_EN_PREF: reg_rdata[NUM_PORTS-1:0] = en_pref;
                        CR_LOCK:    reg_rdata[NUM_PORTS-1:0] = lock_mask;
                        CR_DISABLE: reg_rdata[NUM_PORTS-1:0] = port_disable;
                    endcase
                end
            end
            BANK_LAST: begin
                for (int i = 0; i < NUM_PORTS; i++)
                    if (reg_idx == IDX_W'(i)) reg_rdata = last_q[i];
            end
            BANK_PREF: begin
                for (int i = 0; i < NUM_PORTS; i++)
                    if (reg_idx == IDX_W'(i)) reg_rdata = pref_q[i];
            end
            BANK_RSVD: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sai_checker.sv
module sai_checker
    import sai_pkg::*;
#(
    parameter int NUM_PORTS = 14,
    parameter int SA_W      = 48,
    parameter int IDX_W     = 4
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            pkt_done,
    input logic [IDX_W-1:0]                pkt_port,
    input logic                            pkt_err,
    input logic                            reg_we,
    input logic [IDX_W+1:0]                reg_addr,
    input logic [NUM_PORTS-1:0]            wbits,
    input logic [NUM_PORTS-1:0]            port_disable,
    input logic [NUM_PORTS-1:0]            lock,
    input logic [NUM_PORTS-1:0][SA_W-1:0]  last_q
);

    localparam logic [IDX_W+1:0] STAT_ADDR = {2'(BANK_CTRL), IDX_W'(CR_DISABLE)};

    // R10: after reset nothing is disabled
    p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (port_disable == '0));

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        localparam logic [IDX_W+1:0] LAST_ADDR = {2'(BANK_LAST), IDX_W'(i)};

        // R2, R11: a disable only rises after a clean packet on this port
        p_rise_needs_clean_pkt_r2: assert property (@(posedge clk) disable iff (rst)
            $rose(port_disable[i]) |->
                $past(pkt_done && !pkt_err && pkt_port == IDX_W'(i)));

        // R9: a disable only falls after a write-1 clear of its bit
        p_sticky_until_clear_r9: assert property (@(posedge clk) disable iff (rst)
            $fell(port_disable[i]) |->
                $past(reg_we && reg_addr == STAT_ADDR && wbits[i]));

        // R8: a locked entry only changes through a processor write
        p_locked_no_learn_r8: assert property (@(posedge clk) disable iff (rst)
            (lock[i] && !(reg_we && reg_addr == LAST_ADDR)) |=> $stable(last_q[i]));
    end

endmodule

bind sa_intrusion sai_checker #(
    .NUM_PORTS(NUM_PORTS), .SA_W(SA_W), .IDX_W(IDX_W)
) u_sai_checker (
    .clk          (clk),
    .rst          (rst),
    .pkt_done     (pkt_done),
    .pkt_port     (pkt_port),
    .pkt_err      (pkt_err),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .wbits        (reg_wdata[NUM_PORTS-1:0]),
    .port_disable (port_disable),
    .lock         (lock_mask),
    .last_q       (last_q)
);

// File: tb/tb_sa_intrusion.sv
module tb_sa_intrusion;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 14;
    localparam int W  = 48;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pkt_done = 1'b0;
    logic [3:0]    pkt_port = '0;
    logic [W-1:0]  pkt_sa = '0;
    logic          pkt_err = 1'b0;
    logic          reg_we = 1'b0;
    logic [5:0]    reg_addr = '0;
    logic [W-1:0]  reg_wdata = '0;
    logic [W-1:0]  reg_rdata;
    logic [NP-1:0] port_disable;

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_req  = "R10";

    // behavioural reference state
    logic [W-1:0]  m_last [NP];
    logic [W-1:0]  m_pref [NP];
    logic [NP-1:0] m_en_last, m_en_pref, m_lock, m_dis;

    sa_intrusion dut (
        .clk(clk), .rst(rst), .pkt_done(pkt_done), .pkt_port(pkt_port),
        .pkt_sa(pkt_sa), .pkt_err(pkt_err), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_disable(port_disable)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [5:0] a_last(int p); return 6'h10 + 6'(p); endfunction
    function automatic logic [5:0] a_pref(int p); return 6'h20 + 6'(p); endfunction

    function automatic logic [W-1:0] model_read(logic [5:0] a);
        int idx = int'(a[3:0]);
        case (a[5:4])
            2'd0: case (idx)
                0: return W'(m_en_last);
                1: return W'(m_en_pref);
                2: return W'(m_lock);
                3: return W'(m_dis);
                default: return '0;
            endcase
            2'd1: return (idx < NP) ? m_last[idx] : '0;
            2'd2: return (idx < NP) ? m_pref[idx] : '0;
            default: return '0;
        endcase
    endfunction

    // reference model, evaluated from the requirements
    always @(posedge clk) begin : model
        logic [NP-1:0] nd;
        logic hl, hp, fail;
        int p, idx;
        if (rst) begin
            for (int i = 0; i < NP; i++) begin m_last[i] = '0; m_pref[i] = '0; end
            m_en_last = '0; m_en_pref = '0; m_lock = '0; m_dis = '0;
        end else begin
            nd = m_dis;
            if (reg_we && reg_addr == 6'h03) nd = nd & ~reg_wdata[NP-1:0];
            p = int'(pkt_port);
            if (pkt_done && !pkt_err && p < NP) begin
                hl = (pkt_sa == m_last[p]);
                hp = (pkt_sa == m_pref[p]);
                if (!m_en_last[p] && !m_en_pref[p])      fail = 1'b0;
                else if (m_en_last[p] && !m_en_pref[p])  fail = !hl;
                else if (!m_en_last[p] && m_en_pref[p])  fail = !hp;
                else                                     fail = !hl && !hp;
                if (fail) nd[p] = 1'b1;
                if (!m_lock[p] && !hl) m_last[p] = pkt_sa;
            end
            idx = int'(reg_addr[3:0]);
            if (reg_we) begin
                case (reg_addr[5:4])
                    2'd0: case (idx)
                        0: m_en_last = reg_wdata[NP-1:0];
                        1: m_en_pref = reg_wdata[NP-1:0];
                        2: m_lock    = reg_wdata[NP-1:0];
                        default: ;
                    endcase
                    2'd1: if (idx < NP) m_last[idx] = reg_wdata;
                    2'd2: if (idx < NP) m_pref[idx] = reg_wdata;
                    default: ;
                endcase
            end
            m_dis = nd;
        end
    end

    task automatic check(string what, logic [W-1:0] got, logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
        end
    endtask

    // compare outputs a quarter period after every edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (!rst) begin
            check("port_disable", W'(port_disable), W'(m_dis));
            check("reg_rdata", reg_rdata, model_read(reg_addr));
        end
    end

    task automatic cyc(logic we, logic [5:0] a, logic [W-1:0] d,
                       logic pd, int p, logic [W-1:0] sa, logic err);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d;
        pkt_done = pd; pkt_port = 4'(p); pkt_sa = sa; pkt_err = err;
    endtask

    task automatic wr(logic [5:0] a, logic [W-1:0] d);
        cyc(1'b1, a, d, 1'b0, 0, '0, 1'b0);
    endtask

    task automatic rd(logic [5:0] a);
        cyc(1'b0, a, '0, 1'b0, 0, '0, 1'b0);
    endtask

    task automatic pkt(int p, logic [W-1:0] sa, logic err);
        cyc(1'b0, (p < NP) ? a_last(p) : 6'h03, '0, 1'b1, p, sa, err);
    endtask

    task automatic sweep();
        for (int a = 0; a < 64; a++) rd(6'(a));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: every register reads zero after reset
        cur_req = "R10";
        sweep();

        // R1: program both address banks and read them back
        cur_req = "R1";
        for (int p = 0; p < NP; p++) begin
            wr(a_pref(p), 48'hA0A0_0000_0000 + W'(p));
            wr(a_last(p), 48'hB0B0_0000_0000 + W'(p));
        end
        wr(6'h3F, 48'hFFFF_FFFF_FFFF);
        sweep();

        // R3: nothing enabled, no port ever disabled (but learning runs)
        cur_req = "R3";
        for (int p = 0; p < NP; p++) pkt(p, 48'hC0C0_0000_0000 + W'(p), 1'b0);

        // R7: unlocked port learns a new address, same address keeps it
        cur_req = "R7";
        pkt(0, 48'h0102_0304_0506, 1'b0);
        pkt(0, 48'h0102_0304_0506, 1'b0);
        rd(a_last(0));

        // R4: learned reference only, port 1 locked
        cur_req = "R4";
        wr(6'h02, W'(14'b00_0000_0000_0010));
        wr(6'h00, W'(14'b01_0000_0000_1010));
        wr(a_last(1), 48'h1111_1111_1111);
        pkt(1, 48'h1111_1111_1111, 1'b0);
        pkt(1, 48'h2222_2222_2222, 1'b0);
        // R8: lock held the learned address; processor write still lands
        cur_req = "R8";
        rd(a_last(1));
        wr(a_last(1), 48'h3333_3333_3333);
        rd(a_last(1));
        // R9: write-1 clear releases only the written bit
        cur_req = "R9";
        wr(6'h03, W'(14'b00_0000_0000_0010));
        rd(6'h03);
        // R4 on the attachment-unit port (index 12), unlocked
        cur_req = "R4";
        pkt(12, 48'h4444_4444_4444, 1'b0);
        pkt(12, 48'h4444_4444_4444, 1'b0);
        rd(6'h03);

        // R5: preferred reference only on ports 2 and 13
        cur_req = "R5";
        wr(6'h01, W'(14'b10_0000_0000_1100));
        pkt(2, 48'hA0A0_0000_0002, 1'b0);
        pkt(2, 48'h5555_5555_5555, 1'b0);
        pkt(13, 48'hA0A0_0000_000D, 1'b0);
        pkt(13, 48'h5555_5555_5555, 1'b0);

        // R6: both references on port 3
        cur_req = "R6";
        wr(a_last(3), 48'h6666_6666_6666);
        pkt(3, 48'h6666_6666_6666, 1'b0);
        pkt(3, 48'hA0A0_0000_0003, 1'b0);
        pkt(3, 48'hA0A0_0000_0003, 1'b0);
        pkt(3, 48'h6666_6666_6666, 1'b0);
        rd(6'h03);

        // R2: errored packets neither disable nor learn
        cur_req = "R2";
        wr(6'h03, W'({NP{1'b1}}));
        pkt(1, 48'h7777_7777_7777, 1'b1);
        pkt(12, 48'h7777_7777_7777, 1'b1);
        rd(a_last(12));
        rd(6'h03);

        // R11: out-of-range port index is ignored
        cur_req = "R11";
        pkt(14, 48'h8888_8888_8888, 1'b0);
        pkt(15, 48'h8888_8888_8888, 1'b0);
        wr(6'h1E, 48'h9999_9999_9999);
        rd(6'h1E);
        rd(6'h03);

        // R9: same-cycle clear plus intrusion, and write plus learn
        cur_req = "R9";
        cyc(1'b1, 6'h03, W'(14'b00_0000_0000_0100), 1'b1, 2, 48'hDEAD_0000_0002, 1'b0);
        rd(6'h03);
        cyc(1'b1, a_last(12), 48'hBEEF_0000_000C, 1'b1, 12, 48'hCAFE_0000_000C, 1'b0);
        rd(a_last(12));
        rd(6'h03);

        cur_req = "R1";
        sweep();
        rd(6'h00);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule